// File: doc/BRIEF.md
# Free-Running Timer Counter with Overflow Flag

This block is a free-running up-counter, 16 bits wide by default, paired with an 8-bit flag register. The top bit of the flag register records that the counter has wrapped from its all-ones value back to zero. A small register bus reads the counter as two bytes. The same bus reads the flag register and clears it with write-one-to-clear semantics. When its enable input is high, the overflow flag drives an interrupt request.

Four control bits arrive as plain inputs from a control register elsewhere: counter enable, compare-reset mode, fast-clear mode and overflow interrupt enable. In compare-reset mode, the counter restarts from zero once it has reached a compare value supplied by channel 3. A restart of this kind never counts as an overflow. In fast-clear mode, any access to the counter bytes also empties the flag register, so software needs no separate clearing write.

The bus is a single-cycle register port with no back-pressure. An access is taken in every cycle in which `bus_sel` is high. Read data is combinational from the address and is valid in that same cycle.

Top module: `tmr_ovf_unit`

## Requirements
- R1: After reset the counter reads 0x0000, the flag register reads 0x00 and `ovf_irq` is low.
- R2: The counter changes only on a clock edge where `cnt_en` and `tick` are both high. It holds its value in every other cycle.
- R3: A count step taken from the all-ones value (0xFFFF at the default width) wraps the counter to zero and sets bit 7 of the flag register (address 2).
- R4: A write to address 2 with bit 7 set clears the overflow flag. A write with bit 7 clear leaves the flag unchanged.
- R5: Bits 6..0 of the flag register always read 0, and writes to those bits have no effect.
- R6: `ovf_irq` is high exactly when the overflow flag is set and `ovf_irq_en` is high.
- R7: While `fast_clr_en` is high, any read or write at address 0 or 1 clears the whole flag register at the next edge. While `fast_clr_en` is low, such accesses leave the flags alone.
- R8: With `cmp_rst_en` high, a count step taken while the counter equals `cmp3_val` reloads the counter to zero instead of incrementing it.
- R9: With `cmp_rst_en` high and `cmp3_val` all ones, the counter's return from all ones to zero does not set the overflow flag.
- R10: When an overflow and a clearing action (a write-one-to-clear or a fast clear) fall on the same edge, the flag ends up set.
- R11: An overflow flag that is already set does not block a later overflow, and that later overflow leaves the flag set.
- R12: The counter's high byte reads at address 0 and its low byte reads at address 1. Writes to those addresses do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter enable |
| tick | input | 1 | Single-cycle count strobe |
| cmp_rst_en | input | 1 | Compare-reset mode enable |
| cmp3_val | input | CNT_W | Channel-3 compare value |
| fast_clr_en | input | 1 | Flags clear on counter access |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 counter high, 1 counter low, 2 flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Two actions can land on the same edge: the overflow that sets the flag, and a clearing action, which is either a write-one-to-clear at address 2 or a fast-clear access to a counter byte. The bench provokes each case by holding `tick` high at the last count step before the wrap while it drives the clearing access in that same cycle. One of these runs starts with the flag clear. Another starts with the flag already set, which also covers R11. After the edge, the flag is read back at address 2 and must be set. A separate access on a later cycle must then clear it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int OVF_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    RG_CNT_HI = 2'd0,
    RG_CNT_LO = 2'd1,
    RG_FLAGS  = 2'd2,
    RG_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_bus_dec.sv
module tmr_bus_dec
  import tmr_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output reg_sel_e          rd_sel,
  output logic              cnt_touch,
  output logic [BYTE_W-1:0] clr_mask
);
  always_comb begin
    rd_sel = reg_sel_e'(bus_addr);
    cnt_touch = bus_sel && (rd_sel == RG_CNT_HI || rd_sel == RG_CNT_LO);
    clr_mask = (bus_sel && bus_wr && rd_sel == RG_FLAGS) ? bus_wdata : '0;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             tick,
  input  logic             cmp_rst_en,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic step;
  logic cmp_hit;

  always_comb begin
    step    = cnt_en && tick;
    cmp_hit = cmp_rst_en && (cnt_q == cmp_val);
    ovf_evt = step && !cmp_hit && (cnt_q == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (step)   cnt_q <= cmp_hit ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_flag_reg.sv
module tmr_flag_reg
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovf_evt,
  input  logic              fast_clr,
  input  logic [BYTE_W-1:0] clr_mask,
  output logic [BYTE_W-1:0] flag_q
);
  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    logic set_src;
    if (b == OVF_BIT) begin : g_ovf
      assign set_src = ovf_evt;
    end else begin : g_rsvd
      assign set_src = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      flag_q[b] <= 1'b0;
      else if (set_src)                flag_q[b] <= 1'b1;
      else if (fast_clr || clr_mask[b]) flag_q[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_ovf_unit.sv
module tmr_ovf_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              tick,
  input  logic              cmp_rst_en,
  input  logic [CNT_W-1:0]  cmp3_val,
  input  logic              fast_clr_en,
  input  logic              ovf_irq_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              ovf_irq
);
  localparam int RD_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_evt;
  logic [BYTE_W-1:0] flag_q;
  logic [BYTE_W-1:0] clr_mask;
  logic              cnt_touch;
  reg_sel_e          rd_sel;
  logic [RD_W-1:0]   cnt_ext;

  tmr_bus_dec u_dec (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_sel    (rd_sel),
    .cnt_touch (cnt_touch),
    .clr_mask  (clr_mask)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .tick       (tick),
    .cmp_rst_en (cmp_rst_en),
    .cmp_val    (cmp3_val),
    .cnt_q      (cnt_q),
    .ovf_evt    (ovf_evt)
  );

  tmr_flag_reg u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovf_evt  (ovf_evt),
    .fast_clr (fast_clr_en && cnt_touch),
    .clr_mask (clr_mask),
    .flag_q   (flag_q)
  );

  always_comb begin
    cnt_ext = RD_W'(cnt_q);
    unique case (rd_sel)
      RG_CNT_HI: bus_rdata = cnt_ext[RD_W-1:BYTE_W];
      RG_CNT_LO: bus_rdata = cnt_ext[BYTE_W-1:0];
      RG_FLAGS:  bus_rdata = flag_q;
      default:   bus_rdata = '0;
    endcase
    ovf_irq = flag_q[OVF_BIT] && ovf_irq_en;
  end
endmodule

// File: rtl/tmr_ovf_chk.sv
module tmr_ovf_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic              tick,
  input logic              cmp_rst_en,
  input logic [CNT_W-1:0]  cmp3_val,
  input logic              fast_clr_en,
  input logic              ovf_irq_en,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              ovf_irq,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              ovf_flag
);
  localparam logic [CNT_W-1:0] ALL1 = '1;

  logic wrap_now;
  logic rd_flags;
  assign wrap_now = cnt_en && tick && cnt_q == ALL1 && !(cmp_rst_en && cmp3_val == ALL1);
  assign rd_flags = bus_sel && !bus_wr && bus_addr == 2'd2;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_en && tick) |=> $stable(cnt_q));

  // R3 and R10: an overflow sets the flag, whatever clears in that same cycle
  assert_wrap_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_now |=> ovf_flag);

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd2 && bus_wdata[7] && !wrap_now) |=> !ovf_flag);

  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flags |-> bus_rdata[6:0] == 7'd0);

  assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && ovf_irq_en) |-> ovf_irq == bus_rdata[7]);

  assert_fast_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_clr_en && bus_sel && bus_addr[1] == 1'b0 && !wrap_now) |=> !ovf_flag);

  assert_cmp_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && tick && cmp_rst_en && cnt_q == cmp3_val) |=> cnt_q == '0);

  assert_no_flag_cmp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && tick && cmp_rst_en && cmp3_val == ALL1 && cnt_q == ALL1 && !ovf_flag) |=> !ovf_flag);
endmodule

bind tmr_ovf_unit tmr_ovf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_en      (cnt_en),
  .tick        (tick),
  .cmp_rst_en  (cmp_rst_en),
  .cmp3_val    (cmp3_val),
  .fast_clr_en (fast_clr_en),
  .ovf_irq_en  (ovf_irq_en),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .ovf_irq     (ovf_irq),
  .cnt_q       (cnt_q),
  .ovf_flag    (flag_q[7])
);

// File: tb/tb_tmr_ovf_unit.sv
module tb_tmr_ovf_unit;
  localparam int CLK_P = 10;
  localparam int W     = 12;
  localparam int MAX   = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic cnt_en = 0, tick = 0, cmp_rst_en = 0, fast_clr_en = 0, ovf_irq_en = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [W-1:0] cmp3_val = '0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic ovf_irq;

  int checks = 0, errors = 0;
  int exp_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_ovf_unit #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tick(tick),
    .cmp_rst_en(cmp_rst_en), .cmp3_val(cmp3_val), .fast_clr_en(fast_clr_en),
    .ovf_irq_en(ovf_irq_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf_irq(ovf_irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int nxt(input int c);
    if (!cnt_en) return c;
    if (cmp_rst_en && c == int'(cmp3_val)) return 0;
    return (c + 1) & MAX;
  endfunction

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_sel = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0;
  endtask

  task automatic ticks(input int n);
    if (n <= 0) return;
    @(negedge clk);
    tick = 1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      exp_cnt = nxt(exp_cnt);
    end
    #1 tick = 0;
  endtask

  task automatic advance_to(input int v);
    ticks(v - exp_cnt);
  endtask

  // one count step with a bus access in the same cycle
  task automatic tick_with(input logic [1:0] a, input logic [7:0] d, input logic w);
    @(negedge clk);
    tick = 1; bus_sel = 1; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    exp_cnt = nxt(exp_cnt);
    #1 tick = 0; bus_sel = 0; bus_wr = 0;
  endtask

  task automatic check_cnt(input string req);
    logic [7:0] hi, lo;
    rd(2'd0, hi);
    rd(2'd1, lo);
    chk(req, "count", int'({hi, lo}), exp_cnt);
  endtask

  task automatic check_flags(input string req, input int exp);
    logic [7:0] d;
    rd(2'd2, d);
    chk(req, "flag register", int'(d), exp);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk("R1", "count high after reset", int'(d), 0);
    rd(2'd1, d); chk("R1", "count low after reset", int'(d), 0);
    check_flags("R1", 8'h00);
    chk("R1", "irq after reset", int'(ovf_irq), 0);
  endtask

  task automatic t_count;
    cnt_en = 0;
    ticks(4);
    check_cnt("R2");
    cnt_en = 1;
    ticks(5);
    repeat (3) @(negedge clk);
    check_cnt("R2");
    advance_to(16'h234 & MAX);
    check_cnt("R12");
    wr(2'd0, 8'hAA);
    wr(2'd1, 8'h55);
    check_cnt("R12");
  endtask

  task automatic t_wrap;
    advance_to(MAX);
    check_cnt("R12");
    check_flags("R3", 8'h00);
    ticks(1);
    check_cnt("R3");
    check_flags("R3", 8'h80);
    chk("R6", "irq with enable low", int'(ovf_irq), 0);
    ovf_irq_en = 1; #1;
    chk("R6", "irq with enable high", int'(ovf_irq), 1);
    wr(2'd2, 8'h7F);
    check_flags("R4", 8'h80);
    check_flags("R5", 8'h80);
    wr(2'd2, 8'h80);
    check_flags("R4", 8'h00);
    chk("R6", "irq after clear", int'(ovf_irq), 0);
  endtask

  task automatic t_collide;
    advance_to(MAX);
    tick_with(2'd2, 8'hFF, 1'b1);
    check_flags("R10", 8'h80);
    fast_clr_en = 1;
    advance_to(MAX);
    tick_with(2'd1, 8'h00, 1'b0);
    check_flags("R11", 8'h80);
    begin
      logic [7:0] d;
      rd(2'd0, d);
    end
    check_flags("R7", 8'h00);
    fast_clr_en = 0;
  endtask

  task automatic t_fast_off;
    advance_to(MAX);
    ticks(1);
    check_flags("R3", 8'h80);
    begin
      logic [7:0] d;
      rd(2'd0, d);
    end
    wr(2'd1, 8'h12);
    check_flags("R7", 8'h80);
    wr(2'd2, 8'h80);
    check_flags("R4", 8'h00);
  endtask

  task automatic t_compare;
    cmp_rst_en = 1;
    cmp3_val = W'(10);
    advance_to(10);
    check_cnt("R8");
    ticks(1);
    chk("R8", "model reloaded", exp_cnt, 0);
    check_cnt("R8");
    ticks(3);
    check_cnt("R8");
    cmp3_val = W'(MAX);
    advance_to(MAX);
    ticks(1);
    check_cnt("R9");
    check_flags("R9", 8'h00);
    chk("R9", "irq stays low", int'(ovf_irq), 0);
    cmp_rst_en = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_count();
    t_wrap();
    t_collide();
    t_fast_off();
    t_compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule